// File: doc/BRIEF.md
# Variable-Length Signed Decimal Add/Subtract Sequencer

This block adds or subtracts one signed decimal field (the source, A) into another (the destination, B). Both fields sit in a private 64-character store. Each character carries one BCD digit, two sign-zone bits and a field-end mark. A field is addressed by its least significant character, which is also its highest address. The field runs toward lower addresses until the character that carries the end mark. The sign lives in the zone bits of the least significant character.

After a start pulse the sequencer proceeds in phases. It first reads the two sign characters, one per cycle. If the effective signs differ, it ten's-complements B in place. It then runs the digit-serial add, alternating source and destination reads and writing each result digit back into B. After a complement add it recomplements the result when no carry came out. It finishes by writing the result sign into the zones of B's least significant character and pulsing `done`. A bench-side port loads and reads the store while the sequencer is idle.

Top module: `decseq_top`

## Requirements
- R1: A stored character is 7 bits wide: bit 6 is the field-end mark, bits 5 and 4 are zone bits Z1 and Z0, and bits 3:0 are a BCD digit. A character written through the test port reads back unchanged.
- R2: An operand is negative when its least significant character has Z1=1 and Z0=0. Every other zone pair means positive. The result sign is written as Z1=1,Z0=0 for negative and Z1=1,Z0=1 for positive.
- R3: When the effective signs match, B receives (|A|+|B|) modulo 10^n, where n is B's length, and it keeps B's sign.
- R4: `overflow` is 1 after an operation exactly when a same-sign add carries out of B's most significant digit. Otherwise it is 0.
- R5: Subtract mode inverts A's sign before the signs are compared.
- R6: When the effective signs differ, B receives ||B|−|A||. The sign is B's when |B|>|A| and the opposite sign otherwise, including the case where the result is zero.
- R7: A source shorter than B is treated as if padded with leading zeros. The source characters in the store are never modified.
- R8: Processing stops at the B character that carries the end mark. Characters below it, and the zones and mark bits of B's non-sign characters, are left unchanged.
- R9: `busy` is high from the cycle after `start` is accepted until `done`. `done` is high for exactly one cycle.
- R10: The sequencer makes at most one store access per cycle.
- R11: After reset, `busy`, `done` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted when idle) |
| isSub | input | 1 | 1 = subtract A from B, 0 = add A to B |
| aAddr | input | ADDR_W | Address of A's least significant character |
| bAddr | input | ADDR_W | Address of B's least significant character |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Carry out of a same-sign add, valid from done |
| tbWe | input | 1 | Test-port write enable (use only while idle) |
| tbAddr | input | ADDR_W | Test-port address |
| tbWdata | input | 7 | Test-port write character |
| tbRdata | output | 7 | Test-port read character at tbAddr |

## Verification
The bench uses the default `ADDR_W` of 6, which gives a 64-character store. Source fields sit at address 20 and destination fields at address 50, each up to 8 digits long, with a marked guard character directly below B. That layout leaves room for full-length carries, zero operands, equal magnitudes, short sources and every zone encoding, and lets each run confirm that neither the source nor the guard was disturbed. Expected digits, signs and overflow are computed with plain 64-bit integer arithmetic.

// File: rtl/decseq_pkg.sv
package decseq_pkg;
  localparam int CHAR_W = 7;
  localparam int MARK_BIT = 6;
  localparam int ZHI_BIT = 5;
  localparam int ZLO_BIT = 4;

  typedef struct packed {
    logic load;
    logic capSignA;
    logic capSignB;
    logic fetchA;
    logic fetchB;
    logic writeSum;
    logic cmplWrite;
    logic rewind;
    logic rewindCarry;
    logic keepCmplCarry;
    logic latchResult;
    logic writeSign;
  } ctlT;

  typedef struct packed {
    logic bMark;
    logic signsDiffer;
    logic anyCarry;
  } statT;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SGA, ST_SGB, ST_ROUTE, ST_CRD, ST_CWR,
    ST_AF, ST_BF, ST_BW, ST_DECIDE, ST_SRD, ST_SWR, ST_FIN
  } stateT;

  function automatic logic zoneMinus(input logic zHi, input logic zLo);
    return zHi & ~zLo;
  endfunction
endpackage

// File: rtl/decseq_digit.sv
module decseq_digit (
  input  logic [3:0] xDig,
  input  logic [3:0] yDig,
  input  logic       cin,
  output logic [3:0] outDig,
  output logic       cout
);
  logic [4:0] raw;
  always_comb begin
    raw = {1'b0, xDig} + {1'b0, yDig} + {4'd0, cin};
    if (raw > 5'd9) begin
      outDig = 4'(raw - 5'd10);
      cout = 1'b1;
    end else begin
      outDig = raw[3:0];
      cout = 1'b0;
    end
  end
endmodule

// File: rtl/decseq_data.sv
module decseq_data
  import decseq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic              isSub,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic              tbWe,
  input  logic [ADDR_W-1:0] tbAddr,
  input  logic [CHAR_W-1:0] tbWdata,
  output logic [CHAR_W-1:0] tbRdata,
  output statT              stat,
  output logic              overflow
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CHAR_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] aPtr, bPtr, bStart, rdAddr, wAddr;
  logic [CHAR_W-1:0] rdChar, wData, bReg;
  logic [3:0]        aDig, sumDig, cmpDig;
  logic              memWe, subOp, aDone, carry, cmplCarryR;
  logic              signA, signB, resMinus, ovfR, sumCout, cmpCout;

  assign rdAddr  = (ctl.fetchA || ctl.capSignA) ? aPtr : bPtr;
  assign rdChar  = store[rdAddr];
  assign tbRdata = store[tbAddr];

  decseq_digit u_sum (.xDig(aDig), .yDig(bReg[3:0]), .cin(carry),
                      .outDig(sumDig), .cout(sumCout));
  decseq_digit u_cmpl (.xDig(4'd9 - bReg[3:0]), .yDig(4'd0), .cin(carry),
                       .outDig(cmpDig), .cout(cmpCout));

  always_comb begin
    memWe = 1'b0;
    wAddr = bPtr;
    wData = '0;
    if (ctl.writeSum) begin
      memWe = 1'b1;
      wData = {bReg[MARK_BIT:ZLO_BIT], sumDig};
    end else if (ctl.cmplWrite) begin
      memWe = 1'b1;
      wData = {bReg[MARK_BIT:ZLO_BIT], cmpDig};
    end else if (ctl.writeSign) begin
      memWe = 1'b1;
      wData = {bReg[MARK_BIT], 1'b1, ~resMinus, bReg[3:0]};
    end else if (tbWe) begin
      memWe = 1'b1;
      wAddr = tbAddr;
      wData = tbWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (memWe) store[wAddr] <= wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aPtr <= '0; bPtr <= '0; bStart <= '0;
      subOp <= 1'b0; aDone <= 1'b0; carry <= 1'b0; cmplCarryR <= 1'b0;
      signA <= 1'b0; signB <= 1'b0; resMinus <= 1'b0; ovfR <= 1'b0;
      aDig <= '0; bReg <= '0;
    end else begin
      if (ctl.load) begin
        aPtr <= aAddr; bPtr <= bAddr; bStart <= bAddr;
        subOp <= isSub; aDone <= 1'b0; carry <= 1'b0;
        cmplCarryR <= 1'b0; ovfR <= 1'b0; resMinus <= 1'b0;
      end
      if (ctl.capSignA) signA <= zoneMinus(rdChar[ZHI_BIT], rdChar[ZLO_BIT]) ^ subOp;
      if (ctl.capSignB) signB <= zoneMinus(rdChar[ZHI_BIT], rdChar[ZLO_BIT]);
      if (ctl.fetchA) begin
        aDig <= aDone ? 4'd0 : rdChar[3:0];
        if (!aDone) aDone <= rdChar[MARK_BIT];
        aPtr <= aPtr - 1'b1;
      end
      if (ctl.fetchB) bReg <= rdChar;
      if (ctl.keepCmplCarry) cmplCarryR <= cmpCout;
      if (ctl.rewind) begin
        bPtr <= bStart;
        carry <= ctl.rewindCarry;
      end else if (ctl.cmplWrite) begin
        carry <= cmpCout;
        bPtr <= bPtr - 1'b1;
      end else if (ctl.writeSum) begin
        carry <= sumCout;
        bPtr <= bPtr - 1'b1;
      end
      if (ctl.latchResult) begin
        resMinus <= (signA != signB) ? ((carry | cmplCarryR) ? ~signB : signB) : signB;
        ovfR <= (signA == signB) & carry;
      end
    end
  end

  assign stat.bMark       = bReg[MARK_BIT];
  assign stat.signsDiffer = signA ^ signB;
  assign stat.anyCarry    = carry | cmplCarryR;
  assign overflow         = ovfR;

  // R3: digits produced by the sequencer stay within BCD for BCD operands
  p_bcd_digit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeSum || ctl.cmplWrite) |-> (wData[3:0] <= 4'd9));
endmodule

// File: rtl/decseq_ctrl.sv
module decseq_ctrl
  import decseq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  statT stat,
  output ctlT  ctl,
  output logic busy,
  output logic done
);
  stateT state, nextState;
  logic  pass, nextPass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pass <= 1'b0;
    end else begin
      state <= nextState;
      pass <= nextPass;
    end
  end

  always_comb begin
    ctl = '0;
    nextState = state;
    nextPass = pass;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.load = 1'b1;
        nextPass = 1'b0;
        nextState = ST_SGA;
      end
      ST_SGA: begin
        ctl.capSignA = 1'b1;
        nextState = ST_SGB;
      end
      ST_SGB: begin
        ctl.capSignB = 1'b1;
        nextState = ST_ROUTE;
      end
      ST_ROUTE: begin
        ctl.rewind = 1'b1;
        ctl.rewindCarry = stat.signsDiffer;
        nextState = stat.signsDiffer ? ST_CRD : ST_AF;
      end
      ST_CRD: begin
        ctl.fetchB = 1'b1;
        nextState = ST_CWR;
      end
      ST_CWR: begin
        ctl.cmplWrite = 1'b1;
        if (stat.bMark) begin
          ctl.rewind = 1'b1;
          ctl.rewindCarry = 1'b0;
          ctl.keepCmplCarry = ~pass;
          nextState = pass ? ST_SRD : ST_AF;
        end else begin
          nextState = ST_CRD;
        end
      end
      ST_AF: begin
        ctl.fetchA = 1'b1;
        nextState = ST_BF;
      end
      ST_BF: begin
        ctl.fetchB = 1'b1;
        nextState = ST_BW;
      end
      ST_BW: begin
        ctl.writeSum = 1'b1;
        nextState = stat.bMark ? ST_DECIDE : ST_AF;
      end
      ST_DECIDE: begin
        ctl.latchResult = 1'b1;
        ctl.rewind = 1'b1;
        if (stat.signsDiffer && !stat.anyCarry) begin
          ctl.rewindCarry = 1'b1;
          nextPass = 1'b1;
          nextState = ST_CRD;
        end else begin
          nextState = ST_SRD;
        end
      end
      ST_SRD: begin
        ctl.fetchB = 1'b1;
        nextState = ST_SWR;
      end
      ST_SWR: begin
        ctl.writeSign = 1'b1;
        nextState = ST_FIN;
      end
      ST_FIN: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: no more than one store access per cycle
  p_one_access_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.capSignA, ctl.capSignB, ctl.fetchA, ctl.fetchB,
              ctl.writeSum, ctl.cmplWrite, ctl.writeSign}));
  // R8: the end-marked B character closes the add phase
  p_mark_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BW && stat.bMark) |=> (state == ST_DECIDE));
  // R9: busy covers the cycle of the done pulse
  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));
endmodule

// File: rtl/decseq_top.sv
module decseq_top
  import decseq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isSub,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  input  logic              tbWe,
  input  logic [ADDR_W-1:0] tbAddr,
  input  logic [6:0]        tbWdata,
  output logic [6:0]        tbRdata
);
  ctlT  ctl;
  statT stat;

  decseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat),
    .ctl(ctl), .busy(busy), .done(done)
  );

  decseq_data #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .isSub(isSub),
    .aAddr(aAddr), .bAddr(bAddr), .tbWe(tbWe), .tbAddr(tbAddr),
    .tbWdata(tbWdata), .tbRdata(tbRdata), .stat(stat), .overflow(overflow)
  );
endmodule

// File: tb/decseq_top_test.sv
`timescale 1ns/1ps
module decseq_top_test;
  localparam int ALOW = 20;
  localparam int BLOW = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, isSub = 1'b0, tbWe = 1'b0;
  logic [5:0] aAddr = '0, bAddr = '0, tbAddr = '0;
  logic [6:0] tbWdata = '0;
  logic busy, done, overflow;
  logic [6:0] tbRdata;
  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  decseq_top uut (
    .clk(clk), .rstN(rstN), .start(start), .isSub(isSub),
    .aAddr(aAddr), .bAddr(bAddr), .busy(busy), .done(done),
    .overflow(overflow), .tbWe(tbWe), .tbAddr(tbAddr),
    .tbWdata(tbWdata), .tbRdata(tbRdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic putChar(input int addr, input logic [6:0] ch);
    tbAddr = 6'(addr); tbWdata = ch; tbWe = 1'b1;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic getChar(input int addr, output logic [6:0] ch);
    tbAddr = 6'(addr);
    #0.5;
    ch = tbRdata;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) putChar(i, 7'h00);
  endtask

  // fields: low digit at 'low', mark on most significant char, zones only on low digit
  task automatic putField(input int low, input int len, input longint mag,
                          input logic [1:0] zone);
    longint m = mag;
    for (int i = 0; i < len; i++) begin
      putChar(low - i, {(i == len - 1), (i == 0) ? zone : 2'b00, 4'(m % 10)});
      m = m / 10;
    end
  endtask

  task automatic runCase(input string tag, input longint aMag, input int aLen,
                         input logic [1:0] aZone, input longint bMag, input int bLen,
                         input logic [1:0] bZone, input bit sub);
    longint modv = 1, expMag, gotMag = 0, aBack = 0, w = 1;
    bit aNeg, bNeg, expNeg, expOvf;
    logic [6:0] ch;
    int n = 0;
    bit okA = 1, okZ = 1;
    for (int i = 0; i < bLen; i++) modv *= 10;
    aNeg = (aZone == 2'b10) ^ sub;
    bNeg = (bZone == 2'b10);
    if (aNeg == bNeg) begin
      expMag = (aMag + bMag) % modv; expOvf = (aMag + bMag) >= modv; expNeg = bNeg;
    end else if (aMag >= bMag) begin
      expMag = aMag - bMag; expOvf = 0; expNeg = aNeg;
    end else begin
      expMag = bMag - aMag; expOvf = 0; expNeg = bNeg;
    end
    clearMem();
    putField(ALOW, aLen, aMag, aZone);
    putField(BLOW, bLen, bMag, bZone);
    putChar(BLOW - bLen, 7'h45);
    aAddr = 6'(ALOW); bAddr = 6'(BLOW); isSub = sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9", {tag, " busy after start"}, busy, 1);
    while (done !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    check(done === 1'b1, "R9", {tag, " done seen"}, done, 1);
    check(overflow === expOvf, "R4", {tag, " overflow"}, overflow, expOvf);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R9", {tag, " done one cycle"}, done, 0);
    for (int i = 0; i < bLen; i++) begin
      getChar(BLOW - i, ch);
      gotMag += w * ch[3:0]; w *= 10;
      if (i > 0 && ch[5:4] != 2'b00) okZ = 0;
      if (ch[6] != (i == bLen - 1)) okZ = 0;
    end
    check(gotMag == expMag, (aNeg == bNeg) ? "R3" : "R6", {tag, " magnitude"}, gotMag, expMag);
    getChar(BLOW, ch);
    check(ch[5:4] == (expNeg ? 2'b10 : 2'b11), "R2", {tag, " sign zones"}, ch[5:4],
          expNeg ? 2 : 3);
    check(okZ, "R8", {tag, " B zones/marks kept"}, okZ, 1);
    getChar(BLOW - bLen, ch);
    check(ch == 7'h45, "R8", {tag, " guard below B"}, ch, 7'h45);
    w = 1;
    for (int i = 0; i < aLen; i++) begin
      getChar(ALOW - i, ch);
      aBack += w * ch[3:0]; w *= 10;
      if (ch[5:4] != ((i == 0) ? aZone : 2'b00)) okA = 0;
    end
    check(aBack == aMag && okA, "R7", {tag, " source untouched"}, aBack, aMag);
  endtask

  task automatic testReset();
    check(busy === 1'b0 && done === 1'b0 && overflow === 1'b0, "R11", "reset outputs",
          {busy, done, overflow}, 0);
  endtask

  task automatic testPort();
    logic [6:0] ch;
    putChar(5, 7'h5A);
    putChar(6, 7'h27);
    getChar(5, ch);
    check(ch == 7'h5A, "R1", "port readback 5", ch, 7'h5A);
    getChar(6, ch);
    check(ch == 7'h27, "R1", "port readback 6", ch, 7'h27);
  endtask

  task automatic testTrueAdd();
    runCase("R3 plus+plus", 1234, 4, 2'b11, 4321, 4, 2'b11, 0);
    runCase("R3 minus+minus", 58, 2, 2'b10, 67, 3, 2'b10, 0);
    runCase("R2 zone00 plus", 9, 1, 2'b00, 91, 2, 2'b01, 0);
  endtask

  task automatic testOverflow();
    runCase("R4 carry out", 1, 1, 2'b11, 999, 3, 2'b11, 0);
    runCase("R4 wide carry", 99999999, 8, 2'b11, 99999999, 8, 2'b11, 0);
  endtask

  task automatic testSubMode();
    runCase("R5 sub pos", 20, 2, 2'b11, 50, 2, 2'b11, 1);
    runCase("R5 sub neg", 20, 2, 2'b10, 50, 2, 2'b11, 1);
  endtask

  task automatic testMixed();
    runCase("R6 B larger", 30, 2, 2'b11, 70, 2, 2'b10, 0);
    runCase("R6 A larger", 700, 3, 2'b10, 30, 3, 2'b11, 0);
    runCase("R6 equal", 456, 3, 2'b10, 456, 3, 2'b11, 0);
    runCase("R6 zero B", 42, 2, 2'b10, 0, 4, 2'b11, 0);
    runCase("R6 both zero", 0, 1, 2'b10, 0, 2, 2'b11, 0);
  endtask

  task automatic testShortA();
    runCase("R7 short A add", 7, 1, 2'b11, 99995, 5, 2'b11, 0);
    runCase("R7 short A diff", 7, 1, 2'b11, 10000, 5, 2'b11, 1);
  endtask

  task automatic testRandom();
    for (int k = 0; k < 40; k++) begin
      int bl = 1 + $urandom_range(0, 7);
      int al = 1 + $urandom_range(0, bl - 1);
      longint am = 0, bm = 0;
      for (int i = 0; i < al; i++) am = am * 10 + $urandom_range(0, 9);
      for (int i = 0; i < bl; i++) bm = bm * 10 + $urandom_range(0, 9);
      runCase("R3/R6 random", am, al, 2'($urandom_range(0, 3)), bm, bl,
              2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testPort();
    testTrueAdd();
    testOverflow();
    testSubMode();
    testMixed();
    testShortA();
    testRandom();
    finish();
  end

  initial begin
    repeat (180000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish();
  end
endmodule